// File: doc/BRIEF.md
# Seven-Register Bus Datapath

This block is the execution core of a small horizontally microcoded processor. It holds seven general-purpose registers, two source buses that each pick one register or an external data word, an arithmetic and logic unit, and a write-back decoder. Each clock cycle a 14-bit control word names the two sources, the operation and the destination. That cycle's micro-operation is then fully described.

The ALU result is combinational. It appears on the data output in the same cycle that the control word is presented. On the next rising clock edge it is stored into the register named by the destination field. A destination code of zero stores nothing. This lets a sequencer send a register, or the input word, to the output without disturbing any state. All arithmetic wraps modulo 2^WIDTH. No flags are kept.

Top module: `regdp_core`

## Requirements
- R1: The control word is split as source A in bits 13:11, source B in bits 10:8, destination in bits 7:5 and operation code in bits 4:0.
- R2: A source code of 0 puts dataIn on that bus, and codes 1 to 7 put register R1 to R7 on it. This holds for both the A and B buses.
- R3: A destination code n from 1 to 7 stores the ALU result into Rn at the rising clock edge. The new value is readable in the following cycle.
- R4: A destination code of 0 leaves all seven registers unchanged.
- R5: The arithmetic codes are 00000 pass A, 00001 A+1, 00010 A+B, 00101 A-B and 00110 A-1. All of them wrap modulo 2^WIDTH.
- R6: The logic codes are 01000 A AND B, 01010 A OR B, 01100 A XOR B and 01110 bitwise NOT A.
- R7: Code 10000 shifts A right by one and code 11000 shifts A left by one. Each fills the vacated bit with 0.
- R8: Any operation code not listed in R5 to R7 gives a result of zero, and that zero is still written according to the destination field.
- R9: dataOut shows the ALU result of the current control word and dataIn in the same cycle, with no register in between.
- R10: A synchronous reset clears R1 to R7 to zero. Reset overrides any write requested in the same cycle.
- R11: XOR of a register with itself, written back to that register, clears it. An example is control word 101 101 101 01100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register writes on rising edge |
| rst | input | 1 | Synchronous active-high reset of R1..R7 |
| ctrlWord | input | 14 | Micro-operation: srcA, srcB, dest, opcode |
| dataIn | input | WIDTH | External word selectable on either bus |
| dataOut | output | WIDTH | Combinational ALU result |

## Verification
Registers are first loaded with distinct values through the input word, so each register can be told apart from the others when it is read back. Each opcode is then applied to operand pairs chosen to separate similar operations. Examples are operands where AND, OR and XOR all give different answers, and the top and bottom bits set so that the shift direction and the zero fill show. Wrap-around is exercised at all-ones and at zero. Destination-zero operations, unlisted opcodes and reset with a concurrent write request are each followed by a read-back of every register. This shows whether state was touched.

// File: rtl/regdp_pkg.sv
package regdp_pkg;
  localparam int NUM_REGS = 7;
  localparam int SEL_W    = 3;
  localparam int OPC_W    = 5;
  localparam int CW_W     = 3 * SEL_W + OPC_W;

  // field positions within the control word
  localparam int OPC_LSB  = 0;
  localparam int DST_LSB  = OPC_LSB + OPC_W;
  localparam int SRCB_LSB = DST_LSB + SEL_W;
  localparam int SRCA_LSB = SRCB_LSB + SEL_W;

  // dense internal operation code, decoded from the sparse opcode
  typedef enum logic [3:0] {
    ALU_PASS, ALU_INC, ALU_ADD, ALU_SUB, ALU_DEC,
    ALU_AND,  ALU_OR,  ALU_XOR, ALU_NOT, ALU_SHR,
    ALU_SHL,  ALU_ZERO
  } aluOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [SEL_W-1:0]    srcA;
    logic [SEL_W-1:0]    srcB;
    logic [NUM_REGS-1:0] wrHot;
    aluOp_e              op;
  } strobe_t;
endpackage

// File: rtl/regdp_ctrl.sv
module regdp_ctrl
  import regdp_pkg::*;
(
  input  logic [CW_W-1:0] ctrlWord,
  output strobe_t         strobe
);
  logic [SEL_W-1:0] dstSel;
  logic [OPC_W-1:0] opc;
  aluOp_e           opDec;
  logic [NUM_REGS-1:0] wrHot;

  assign dstSel = ctrlWord[DST_LSB +: SEL_W];
  assign opc    = ctrlWord[OPC_LSB +: OPC_W];

  always_comb begin
    unique case (opc)
      5'b00000: opDec = ALU_PASS;
      5'b00001: opDec = ALU_INC;
      5'b00010: opDec = ALU_ADD;
      5'b00101: opDec = ALU_SUB;
      5'b00110: opDec = ALU_DEC;
      5'b01000: opDec = ALU_AND;
      5'b01010: opDec = ALU_OR;
      5'b01100: opDec = ALU_XOR;
      5'b01110: opDec = ALU_NOT;
      5'b10000: opDec = ALU_SHR;
      5'b11000: opDec = ALU_SHL;
      default:  opDec = ALU_ZERO;
    endcase
  end

  // destination decoder: code 0 selects no register
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_wrDec
    assign wrHot[i] = (dstSel == SEL_W'(i + 1));
  end

  always_comb begin
    strobe.srcA  = ctrlWord[SRCA_LSB +: SEL_W];
    strobe.srcB  = ctrlWord[SRCB_LSB +: SEL_W];
    strobe.wrHot = wrHot;
    strobe.op    = opDec;
  end
endmodule

// File: rtl/regdp_alu.sv
module regdp_alu
  import regdp_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluOp_e           op,
  output logic [WIDTH-1:0] result
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    unique case (op)
      ALU_PASS: result = opA;
      ALU_INC:  result = opA + ONE;
      ALU_ADD:  result = opA + opB;
      ALU_SUB:  result = opA - opB;
      ALU_DEC:  result = opA - ONE;
      ALU_AND:  result = opA & opB;
      ALU_OR:   result = opA | opB;
      ALU_XOR:  result = opA ^ opB;
      ALU_NOT:  result = ~opA;
      ALU_SHR:  result = {1'b0, opA[WIDTH-1:1]};
      ALU_SHL:  result = {opA[WIDTH-2:0], 1'b0};
      default:  result = '0;
    endcase
  end
endmodule

// File: rtl/regdp_regfile.sv
module regdp_regfile
  import regdp_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_REGS-1:0] wrHot,
  input  logic [WIDTH-1:0]    wrData,
  input  logic [SEL_W-1:0]    srcA,
  input  logic [SEL_W-1:0]    srcB,
  input  logic [WIDTH-1:0]    extIn,
  output logic [WIDTH-1:0]    busA,
  output logic [WIDTH-1:0]    busB
);
  logic [NUM_REGS-1:0][WIDTH-1:0] regBank;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [WIDTH-1:0] regQ;
    always_ff @(posedge clk) begin
      if (rst)           regQ <= '0;
      else if (wrHot[i]) regQ <= wrData;
    end
    assign regBank[i] = regQ;
  end

  // source code 0 picks the external word, n picks register n
  always_comb begin
    busA = (srcA == '0) ? extIn : regBank[srcA - SEL_W'(1)];
    busB = (srcB == '0) ? extIn : regBank[srcB - SEL_W'(1)];
  end
endmodule

// File: rtl/regdp_core.sv
module regdp_core
  import regdp_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW_W-1:0]  ctrlWord,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut
);
  strobe_t          strobe;
  logic [WIDTH-1:0] busA;
  logic [WIDTH-1:0] busB;
  logic [WIDTH-1:0] aluY;

  regdp_ctrl u_ctrl (
    .ctrlWord (ctrlWord),
    .strobe   (strobe)
  );

  regdp_regfile #(.WIDTH(WIDTH)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wrHot  (strobe.wrHot),
    .wrData (aluY),
    .srcA   (strobe.srcA),
    .srcB   (strobe.srcB),
    .extIn  (dataIn),
    .busA   (busA),
    .busB   (busB)
  );

  regdp_alu #(.WIDTH(WIDTH)) u_alu (
    .opA    (busA),
    .opB    (busB),
    .op     (strobe.op),
    .result (aluY)
  );

  assign dataOut = aluY;
endmodule

// File: rtl/regdp_chk.sv
module regdp_chk
  import regdp_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CW_W-1:0]  ctrlWord,
  input logic [WIDTH-1:0] dataIn,
  input logic [WIDTH-1:0] dataOut
);
  logic [SEL_W-1:0] cA, cB, cD;
  logic [OPC_W-1:0] cO;
  logic             knownOp;

  assign cA = ctrlWord[SRCA_LSB +: SEL_W];
  assign cB = ctrlWord[SRCB_LSB +: SEL_W];
  assign cD = ctrlWord[DST_LSB +: SEL_W];
  assign cO = ctrlWord[OPC_LSB +: OPC_W];
  assign knownOp = (cO inside {5'b00000, 5'b00001, 5'b00010, 5'b00101, 5'b00110,
                               5'b01000, 5'b01010, 5'b01100, 5'b01110,
                               5'b10000, 5'b11000});

  // R2, R9: input word passes straight to the output
  a_r9_input_pass: assert property (@(posedge clk) disable iff (rst)
    (cA == '0 && cO == 5'b00000) |-> dataOut == dataIn);

  // R3: value written last cycle is read back unchanged
  a_r3_writeback: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cD) != '0 && cA == $past(cD) && cO == 5'b00000)
      |-> dataOut == $past(dataOut));

  // R10: first cycle after reset every register reads zero
  a_r10_reset_clear: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && cA != '0 && cO == 5'b00000) |-> dataOut == '0);

  // R8: unlisted opcodes produce zero
  a_r8_unknown_zero: assert property (@(posedge clk) disable iff (rst)
    !knownOp |-> dataOut == '0);

  // R11: XOR of a bus with itself is zero
  a_r11_xor_self: assert property (@(posedge clk) disable iff (rst)
    (cA == cB && cO == 5'b01100) |-> dataOut == '0);
endmodule

bind regdp_core regdp_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ctrlWord (ctrlWord),
  .dataIn   (dataIn),
  .dataOut  (dataOut)
);

// File: tb/tb_regdp_core.sv
module tb_regdp_core;
  localparam int W = 16;
  localparam logic [4:0] TSFA = 5'b00000, INCA = 5'b00001, ADD = 5'b00010,
                         SUB = 5'b00101, DECA = 5'b00110, ANDO = 5'b01000,
                         ORO = 5'b01010, XORO = 5'b01100, COMA = 5'b01110,
                         SHRA = 5'b10000, SHLA = 5'b11000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [13:0]   cw  = '0;
  logic [W-1:0]  din = '0;
  logic [W-1:0]  dataOut;
  logic [W-1:0]  mdl [1:7];
  int            total = 0;
  int            bad   = 0;
  bit            finished = 1'b0;

  always #2 clk = ~clk;

  regdp_core #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .ctrlWord(cw), .dataIn(din), .dataOut(dataOut)
  );

  function automatic logic [W-1:0] expRes(input logic [4:0] op,
                                          input logic [W-1:0] a,
                                          input logic [W-1:0] b);
    case (op)
      TSFA: return a;
      INCA: return a + 1'b1;
      ADD:  return a + b;
      SUB:  return a - b;
      DECA: return a - 1'b1;
      ANDO: return a & b;
      ORO:  return a | b;
      XORO: return a ^ b;
      COMA: return ~a;
      SHRA: return a >> 1;
      SHLA: return a << 1;
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", tag, got, exp);
    end
  endtask

  // R1: fields unpacked as A[13:11] B[10:8] D[7:5] OP[4:0]
  task automatic doRaw(input logic [13:0] word, input logic [W-1:0] d, input string tag);
    logic [2:0] sa, sb, sd;
    logic [4:0] op;
    logic [W-1:0] a, b, e;
    sa = word[13:11]; sb = word[10:8]; sd = word[7:5]; op = word[4:0];
    @(negedge clk);
    cw = word; din = d;
    #1;
    a = (sa == 0) ? d : mdl[sa];
    b = (sb == 0) ? d : mdl[sb];
    e = expRes(op, a, b);
    chk(tag, dataOut, e);
    @(posedge clk);
    if (sd != 0) mdl[sd] = e;
  endtask

  task automatic doOp(input logic [2:0] sa, input logic [2:0] sb, input logic [2:0] sd,
                      input logic [4:0] op, input logic [W-1:0] d, input string tag);
    doRaw({sa, sb, sd, op}, d, tag);
  endtask

  task automatic readAll(input string tag);
    for (int k = 1; k <= 7; k++) doOp(3'(k), 3'd0, 3'd0, TSFA, 16'h5A5A, tag);
  endtask

  task automatic applyReset();
    @(negedge clk);
    rst = 1'b1;
    cw  = {3'd0, 3'd0, 3'd1, TSFA};   // write request during reset
    din = 16'hABCD;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cw  = '0;
    for (int k = 1; k <= 7; k++) mdl[k] = '0;
  endtask

  task automatic t_reset();
    applyReset();
    readAll("R10 reset clears");
  endtask

  task automatic t_load();
    for (int k = 1; k <= 7; k++)
      doOp(3'd0, 3'd0, 3'(k), TSFA, 16'h1111 * k[15:0] + 16'h0300, "R2 R3 load via input");
    readAll("R3 readback");
    for (int k = 1; k <= 7; k++)
      doOp(3'd0, 3'(k), 3'd0, ADD, 16'h0000, "R2 B bus select");
  endtask

  task automatic t_arith();
    doOp(3'd1, 3'd0, 3'd2, INCA, 0, "R5 increment");
    doOp(3'd1, 3'd2, 3'd3, ADD, 0, "R5 add");
    doRaw(14'b010_011_001_00101, 0, "R1 R5 subtract layout");
    doOp(3'd0, 3'd0, 3'd4, TSFA, 16'hFFFF, "R5 load all ones");
    doOp(3'd4, 3'd0, 3'd4, INCA, 0, "R5 increment wraps");
    doOp(3'd4, 3'd0, 3'd4, DECA, 0, "R5 decrement wraps");
    doOp(3'd0, 3'd4, 3'd5, SUB, 16'h0000, "R5 subtract underflow");
    doOp(3'd4, 3'd4, 3'd6, ADD, 0, "R5 add overflow");
    readAll("R5 results stored");
  endtask

  task automatic t_logic();
    doOp(3'd0, 3'd0, 3'd1, TSFA, 16'hF0CC, "R6 prep");
    doOp(3'd1, 3'd0, 3'd2, ANDO, 16'h3CAA, "R6 and");
    doOp(3'd1, 3'd0, 3'd3, ORO,  16'h3CAA, "R6 or");
    doOp(3'd1, 3'd0, 3'd4, XORO, 16'h3CAA, "R6 xor");
    doOp(3'd1, 3'd0, 3'd5, COMA, 16'h3CAA, "R6 complement");
    readAll("R6 results stored");
  endtask

  task automatic t_shift();
    doOp(3'd0, 3'd0, 3'd6, TSFA, 16'h8001, "R7 prep");
    doOp(3'd6, 3'd0, 3'd7, SHRA, 0, "R7 shift right zero fill");
    doOp(3'd6, 3'd0, 3'd6, SHLA, 0, "R7 shift left zero fill");
    readAll("R7 results stored");
  endtask

  task automatic t_noWrite();
    doOp(3'd0, 3'd0, 3'd0, TSFA, 16'h7E57, "R9 output from input");
    doOp(3'd1, 3'd2, 3'd0, ADD, 0, "R4 no-dest add");
    doOp(3'd3, 3'd0, 3'd0, COMA, 0, "R4 no-dest complement");
    doOp(3'd0, 3'd0, 3'd0, INCA, 16'hFFFF, "R9 input increment");
    readAll("R4 registers unchanged");
  endtask

  task automatic t_unknown();
    doOp(3'd1, 3'd2, 3'd1, 5'b00011, 0, "R8 opcode 00011");
    doOp(3'd3, 3'd3, 3'd3, 5'b11111, 0, "R8 opcode 11111");
    doOp(3'd0, 3'd0, 3'd2, 5'b10001, 16'hFFFF, "R8 opcode 10001");
    readAll("R8 zero written");
  endtask

  task automatic t_clear();
    doOp(3'd0, 3'd0, 3'd5, TSFA, 16'hBEEF, "R11 prep");
    doRaw(14'b101_101_101_01100, 16'h1234, "R11 xor self");
    doOp(3'd5, 3'd0, 3'd0, TSFA, 0, "R11 register cleared");
  endtask

  initial begin
    for (int k = 1; k <= 7; k++) mdl[k] = '0;
    repeat (2) @(posedge clk);
    t_reset();
    t_load();
    t_arith();
    t_logic();
    t_shift();
    t_noWrite();
    t_unknown();
    t_clear();
    t_load();
    t_reset();   // R10 reset mid-run beats a pending write
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule